// File: doc/BRIEF.md
# Divided-Clock Phase Frequency Detector

This block measures how far a reference signal has drifted against a local clock. Both sides are first slowed by programmable integer dividers: the reference (any clock or pulse train, asynchronous to the local clock) is resynchronised into the local clock domain and then divided, while the local clock is divided directly. Over a measurement window the block keeps a running difference between the number of divided reference events and divided local events.

The window length is a programmable number of phase-update ticks supplied from outside. When the last tick of a window arrives, the running difference is reported on a signed error output for a downstream loop filter and the difference is restarted. A result that does not fit the error width is clamped and marked with an overflow flag. The error holds its value until the next window ends.

Top module: `divclk_phase_detector`

## Requirements
- R1: A synchronous active-high reset, held for at least eight clock cycles, clears the error to zero, the overflow flag to 0 and the window strobe to 0, and restarts the dividers, window count and running difference; the first error seen after reset is zero.
- R2: A reference rising edge is counted only after it has passed a two-stage synchroniser; a reference level held high counts as a single edge however long it stays high.
- R3: With `ref_cnt_en` high, the reference divider produces one event on every (ref_div+2)-th synchronised rising edge; reference edges that arrive while `ref_cnt_en` is low neither count nor advance the divider.
- R4: With `loc_cnt_en` high, the local divider produces one event every loc_div+2 clock cycles; cycles with `loc_cnt_en` low do not advance it.
- R5: The window ends on every (win_rate+1)-th cycle in which `pi_tick` is high; `win_o` is high for exactly the one cycle after that, and never follows a cycle without `pi_tick`.
- R6: At a window end the error becomes (reference events minus local events) accumulated since the previous window end, so a positive value means the reference is ahead; events occurring in the window-end cycle itself belong to the next window.
- R7: Between window ends, `err_o` and `ovf_o` do not change.
- R8: A window difference above 2^(ERR_W-1)-1 reports that maximum, one below -2^(ERR_W-1) reports that minimum, and in both cases `ovf_o` is 1; the next in-range window clears `ovf_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local clock; all state is in this domain |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference clock or pulse, asynchronous |
| ref_div | input | DIV_W | Reference divider setting, divides by value+2 |
| loc_div | input | DIV_W | Local divider setting, divides by value+2 |
| ref_cnt_en | input | 1 | Enables counting of reference edges |
| loc_cnt_en | input | 1 | Enables counting of local cycles |
| pi_tick | input | 1 | Phase-update tick the window is built from |
| win_rate | input | RATE_W | Window length in ticks, minus one |
| err_o | output | ERR_W | Signed window error, reference minus local |
| ovf_o | output | 1 | Error clamped in the last window |
| win_o | output | 1 | One-cycle strobe when err_o is updated |

## Verification
The hardest condition to reach is an overflowing window: at the default 21-bit error the difference needs about a million divided events, far more cycles than a run can spend, since a reference edge needs two clocks at least. The bench therefore builds the block with an 8-bit error and drives the fastest reference with the smallest divider and a long window, then the fastest local division with the reference idle, reaching both clamps in a few thousand cycles. A behavioural model tracks synchroniser delay, divider phase and window position so that windows starting mid-pattern and events landing on the window-end cycle are compared exactly.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    // signed contribution of one cycle to the running difference
    typedef logic signed [1:0] step_t;

    function automatic step_t step_of(input logic ref_ev, input logic loc_ev);
        step_t s;
        case ({ref_ev, loc_ev})
            2'b10:   s = 2'sd1;
            2'b01:   s = -2'sd1;
            default: s = 2'sd0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise_o
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_in;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
        rise_o  = st_q.s2 & ~st_q.s3;
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/pfd_event_div.sv
module pfd_event_div #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic             en_i,
    input  logic [DIV_W-1:0] setting_i,
    output logic             event_o
);
    localparam int CMP_W = DIV_W + 1;

    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [CMP_W-1:0] last_pos;

    always_comb begin
        cnt_d    = cnt_q;
        event_o  = 1'b0;
        last_pos = {1'b0, setting_i} + CMP_W'(1);
        if (tick_i && en_i) begin
            if ({1'b0, cnt_q} >= last_pos) begin
                cnt_d   = '0;
                event_o = 1'b1;
            end else begin
                cnt_d = cnt_q + DIV_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/pfd_window.sv
module pfd_window #(
    parameter int RATE_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pi_tick_i,
    input  logic [RATE_W-1:0] rate_i,
    output logic              end_o
);
    logic [RATE_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        end_o = 1'b0;
        if (pi_tick_i) begin
            if (cnt_q >= rate_i) begin
                cnt_d = '0;
                end_o = 1'b1;
            end else begin
                cnt_d = cnt_q + RATE_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/divclk_phase_detector.sv
module divclk_phase_detector #(
    parameter int DIV_W  = 16,
    parameter int RATE_W = 16,
    parameter int ERR_W  = 21
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ref_in,
    input  logic [DIV_W-1:0]        ref_div,
    input  logic [DIV_W-1:0]        loc_div,
    input  logic                    ref_cnt_en,
    input  logic                    loc_cnt_en,
    input  logic                    pi_tick,
    input  logic [RATE_W-1:0]       win_rate,
    output logic signed [ERR_W-1:0] err_o,
    output logic                    ovf_o,
    output logic                    win_o
);
    import pfd_pkg::*;

    localparam int ACC_W = ERR_W + 3;
    localparam int SUM_W = ACC_W + 1;
    localparam logic signed [ACC_W-1:0] ERR_HI  = ACC_W'((64'sd1 <<< (ERR_W - 1)) - 1);
    localparam logic signed [ACC_W-1:0] ERR_LO  = ACC_W'(-(64'sd1 <<< (ERR_W - 1)));
    localparam logic signed [SUM_W-1:0] ACC_HI  = SUM_W'((64'sd1 <<< (ACC_W - 1)) - 1);
    localparam logic signed [SUM_W-1:0] ACC_LO  = SUM_W'(-(64'sd1 <<< (ACC_W - 1)));

    typedef struct packed {
        logic signed [ACC_W-1:0] acc;
        logic signed [ERR_W-1:0] err;
        logic                    ovf;
        logic                    win;
    } det_t;

    det_t st_d, st_q;

    logic ref_rise;
    logic ref_ev;
    logic loc_ev;
    logic win_end;
    step_t step;
    logic signed [SUM_W-1:0] sum;

    pfd_edge_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (ref_in),
        .rise_o   (ref_rise)
    );

    pfd_event_div #(.DIV_W(DIV_W)) u_ref_div (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (ref_rise),
        .en_i      (ref_cnt_en),
        .setting_i (ref_div),
        .event_o   (ref_ev)
    );

    pfd_event_div #(.DIV_W(DIV_W)) u_loc_div (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (1'b1),
        .en_i      (loc_cnt_en),
        .setting_i (loc_div),
        .event_o   (loc_ev)
    );

    pfd_window #(.RATE_W(RATE_W)) u_win (
        .clk       (clk),
        .rst       (rst),
        .pi_tick_i (pi_tick),
        .rate_i    (win_rate),
        .end_o     (win_end)
    );

    always_comb begin
        st_d     = st_q;
        step     = step_of(ref_ev, loc_ev);
        sum      = SUM_W'(st_q.acc) + SUM_W'(step);
        st_d.win = win_end;
        if (win_end) begin
            if (st_q.acc > ERR_HI) begin
                st_d.err = ERR_HI[ERR_W-1:0];
                st_d.ovf = 1'b1;
            end else if (st_q.acc < ERR_LO) begin
                st_d.err = ERR_LO[ERR_W-1:0];
                st_d.ovf = 1'b1;
            end else begin
                st_d.err = st_q.acc[ERR_W-1:0];
                st_d.ovf = 1'b0;
            end
            st_d.acc = ACC_W'(step);
        end else if (sum > ACC_HI) begin
            st_d.acc = ACC_HI[ACC_W-1:0];
        end else if (sum < ACC_LO) begin
            st_d.acc = ACC_LO[ACC_W-1:0];
        end else begin
            st_d.acc = sum[ACC_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign err_o = st_q.err;
    assign ovf_o = st_q.ovf;
    assign win_o = st_q.win;
endmodule

// File: rtl/pfd_checker.sv
module pfd_checker #(
    parameter int ERR_W = 21
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    pi_tick,
    input logic                    ref_cnt_en,
    input logic                    loc_cnt_en,
    input logic                    ref_ev,
    input logic                    loc_ev,
    input logic signed [ERR_W-1:0] err_o,
    input logic                    ovf_o,
    input logic                    win_o
);
    localparam logic signed [ERR_W-1:0] E_MAX = {1'b0, {(ERR_W-1){1'b1}}};
    localparam logic signed [ERR_W-1:0] E_MIN = {1'b1, {(ERR_W-1){1'b0}}};

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (err_o == '0 && !ovf_o && !win_o));

    a_r3_ref_gated: assert property (@(posedge clk) disable iff (rst)
        !ref_cnt_en |-> !ref_ev);

    a_r4_loc_gated: assert property (@(posedge clk) disable iff (rst)
        !loc_cnt_en |-> !loc_ev);

    a_r5_no_tick_no_window: assert property (@(posedge clk) disable iff (rst)
        !pi_tick |=> !win_o);

    a_r7_hold_between: assert property (@(posedge clk) disable iff (rst)
        (!win_o && !$past(rst)) |-> ($stable(err_o) && $stable(ovf_o)));

    a_r8_ovf_at_limit: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> (err_o == E_MAX || err_o == E_MIN));
endmodule

bind divclk_phase_detector pfd_checker #(.ERR_W(ERR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .pi_tick    (pi_tick),
    .ref_cnt_en (ref_cnt_en),
    .loc_cnt_en (loc_cnt_en),
    .ref_ev     (ref_ev),
    .loc_ev     (loc_ev),
    .err_o      (err_o),
    .ovf_o      (ovf_o),
    .win_o      (win_o)
);

// File: tb/divclk_phase_detector_tb.sv
`timescale 1ns/1ps
module divclk_phase_detector_tb;
    localparam int ERR_W  = 8;
    localparam int E_MAX  = (1 << (ERR_W - 1)) - 1;
    localparam int E_MIN  = -(1 << (ERR_W - 1));
    localparam int A_MAX  = (1 << (ERR_W + 2)) - 1;
    localparam int A_MIN  = -(1 << (ERR_W + 2));

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic [15:0] ref_div = '0, loc_div = '0, win_rate = '0;
    logic ref_cnt_en = 1'b0, loc_cnt_en = 1'b0, pi_tick = 1'b0;
    logic signed [ERR_W-1:0] err_o;
    logic ovf_o, win_o;

    always #2.5 clk = ~clk;

    divclk_phase_detector #(.ERR_W(ERR_W)) u_dut (
        .clk(clk), .rst(rst), .ref_in(ref_in), .ref_div(ref_div), .loc_div(loc_div),
        .ref_cnt_en(ref_cnt_en), .loc_cnt_en(loc_cnt_en), .pi_tick(pi_tick),
        .win_rate(win_rate), .err_o(err_o), .ovf_o(ovf_o), .win_o(win_o)
    );

    int vectors = 0;
    int miscompares = 0;
    string cur_req = "R1";

    // stimulus generator controls
    int ref_mode = 0;   // 0 low, 1 periodic, 2 held high
    int ref_per  = 4;
    int ref_hi   = 2;
    int tick_per = 1;   // 0 means no ticks

    // reference model state
    int m_s1, m_s2, m_s3, m_rc, m_lc, m_wc, m_acc, m_err, m_ovf, m_win;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        int rise, rev, lev, wend;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_rc = 0; m_lc = 0; m_wc = 0;
            m_acc = 0; m_err = 0; m_ovf = 0; m_win = 0;
        end else begin
            rise = (m_s2 == 1 && m_s3 == 0);
            rev = 0; lev = 0; wend = 0;
            if (rise && ref_cnt_en) begin
                if (m_rc >= int'(ref_div) + 1) begin m_rc = 0; rev = 1; end
                else m_rc++;
            end
            if (loc_cnt_en) begin
                if (m_lc >= int'(loc_div) + 1) begin m_lc = 0; lev = 1; end
                else m_lc++;
            end
            if (pi_tick) begin
                if (m_wc >= int'(win_rate)) begin m_wc = 0; wend = 1; end
                else m_wc++;
            end
            if (wend) begin
                if (m_acc > E_MAX)      begin m_err = E_MAX; m_ovf = 1; end
                else if (m_acc < E_MIN) begin m_err = E_MIN; m_ovf = 1; end
                else                    begin m_err = m_acc; m_ovf = 0; end
                m_acc = rev - lev;
            end else begin
                m_acc = m_acc + rev - lev;
                if (m_acc > A_MAX) m_acc = A_MAX;
                if (m_acc < A_MIN) m_acc = A_MIN;
            end
            m_win = wend;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = int'(ref_in);
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        chk(int'(err_o) == m_err, cur_req, int'(err_o), m_err);
        chk(int'(ovf_o) == m_ovf, cur_req, int'(ovf_o), m_ovf);
        chk(int'(win_o) == m_win, cur_req, int'(win_o), m_win);
    end

    // reference and tick generator
    initial begin
        int rph = 0;
        int tph = 0;
        forever begin
            @(negedge clk);
            case (ref_mode)
                1:       ref_in = (rph < ref_hi);
                2:       ref_in = 1'b1;
                default: ref_in = 1'b0;
            endcase
            rph = (rph + 1 >= ref_per) ? 0 : rph + 1;
            if (tick_per == 0) pi_tick = 1'b0;
            else begin
                pi_tick = (tph == 0);
                tph = (tph + 1 >= tick_per) ? 0 : tph + 1;
            end
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_win();
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (win_o) return;
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        miscompares++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        cur_req = "R1";
        rst = 1'b1;
        run(10);
        chk(err_o == 0 && !ovf_o && !win_o, "R1", int'(err_o), 0);
        @(negedge clk); rst = 1'b0;

        // R3: reference division, window every 50 ticks
        cur_req = "R3";
        win_rate = 16'd49; tick_per = 1;
        ref_cnt_en = 1'b1; ref_div = 16'd1;
        ref_mode = 1; ref_per = 4; ref_hi = 2;
        run(400);

        // R2: level held high is a single edge
        cur_req = "R2";
        ref_mode = 2; run(150);
        ref_mode = 1; ref_per = 7; ref_hi = 3; run(200);

        // R3: edges ignored while disabled
        cur_req = "R3";
        ref_cnt_en = 1'b0; run(200);
        ref_cnt_en = 1'b1; run(100);

        // R4: local division only
        cur_req = "R4";
        ref_mode = 0; loc_cnt_en = 1'b1; loc_div = 16'd3; run(300);
        loc_cnt_en = 1'b0; run(100);

        // R6: both sides, events straddling window ends
        cur_req = "R6";
        ref_mode = 1; ref_per = 5; ref_hi = 2; ref_div = 16'd0;
        loc_cnt_en = 1'b1; loc_div = 16'd8; win_rate = 16'd12; run(600);
        ref_per = 3; ref_hi = 1; loc_div = 16'd4; win_rate = 16'd0; run(200);

        // R5: sparse ticks, then none
        cur_req = "R5";
        tick_per = 3; win_rate = 16'd4; run(300);
        cur_req = "R7";
        tick_per = 0; run(150);

        // R8: positive clamp
        cur_req = "R8";
        loc_cnt_en = 1'b0; ref_div = 16'd0; ref_mode = 1; ref_per = 2; ref_hi = 1;
        tick_per = 1; win_rate = 16'd1999;
        wait_win(); wait_win();
        chk(int'(err_o) == E_MAX, "R8", int'(err_o), E_MAX);
        chk(ovf_o == 1'b1, "R8", int'(ovf_o), 1);
        // negative clamp
        ref_mode = 0; loc_cnt_en = 1'b1; loc_div = 16'd0;
        wait_win(); wait_win();
        chk(int'(err_o) == E_MIN, "R8", int'(err_o), E_MIN);
        chk(ovf_o == 1'b1, "R8", int'(ovf_o), 1);
        // back in range clears the flag
        loc_div = 16'd99; win_rate = 16'd999;
        wait_win(); wait_win();
        chk(ovf_o == 1'b0, "R8", int'(ovf_o), 0);
        chk(int'(err_o) == -10, "R6", int'(err_o), -10);

        // R1: reset in the middle of activity
        cur_req = "R1";
        ref_mode = 1; ref_per = 4; ref_hi = 2; win_rate = 16'd20; run(100);
        rst = 1'b1; run(9);
        chk(err_o == 0 && !ovf_o && !win_o, "R1", int'(err_o), 0);
        rst = 1'b0;
        cur_req = "R6";
        run(200);

        finish_run();
    end
endmodule